// File: doc/BRIEF.md
# Mode-Switching Countdown Interrupt Timer

This block is a countdown timer with a small set of write-only registers and an interrupt request output. A configuration register holds an interrupt vector, a mask bit and a two-bit mode field. The mode field selects one of three behaviours: one-shot countdown, periodic countdown with reload, or deadline compare against a free-running 64-bit timebase. Software starts a countdown by writing an initial count. The current count, the stored configuration, the committed deadline and the timebase are visible on output pins. When an armed countdown or deadline expires, the block raises a single-cycle interrupt pulse unless the mask bit is set.

A rewrite of the mode field alone follows fixed rules. Moving between one-shot and periodic leaves a running countdown alone, so it either wraps or stops at its next expiry. It does not restart an expired one. Entering or leaving deadline mode disarms everything. A software-enable input, when low, forces the mask bit on any configuration write.

The register port is a plain one-cycle write strobe with an address and a data word, and it has no back-pressure. Every write takes effect at the clock edge where `wr_en` is high. Address 0 selects the configuration register. Address 1 selects the initial count. Address 2 stages the low deadline word. Address 3 supplies the high word and commits the full deadline.

Top module: `mode_countdown_timer`

## Requirements
- R1: A write to address 1 outside deadline mode loads both the current count and the stored initial count with the written value. Counting starts from that value. Writing zero stops the countdown with the current count at zero.
- R2: In one-shot mode (mode field 2'b00) the count drops by one per clock. When the count goes from 1 to 0, `irq_o` goes high in the same cycle that `count_o` first reads zero. The count then stays at zero.
- R3: In periodic mode (mode field 2'b01) each expiry reloads the count from the stored initial count and raises one pulse. With initial count N, pulses fall every N cycles.
- R4: Rewriting the mode from one-shot to periodic while the count is nonzero does not alter the count. At the next expiry the count wraps back to the initial count.
- R5: Rewriting the mode to periodic after a one-shot count has already reached zero leaves the count at zero and produces no interrupt.
- R6: Rewriting the mode from periodic to one-shot while the count is running lets it reach zero with one final pulse and no reload.
- R7: A configuration write that moves into or out of deadline mode (mode field 2'b10) clears the current count and the committed deadline, and no interrupt follows from the earlier setting.
- R8: While in deadline mode, writes to address 1 leave the current count unchanged.
- R9: In deadline mode, once the timebase is greater than or equal to a nonzero committed deadline, one pulse is raised in the following cycle and the deadline clears to zero. The deadline is staged through address 2 (low word) and committed by address 3 (high word). A deadline already in the past fires one cycle after commit.
- R10: The configuration register stores only vector bits [7:0], mask bit 16 and mode bits [18:17]; all other bits read zero. Reset value is 32'h0001_0000. When `sw_en` is low, a configuration write stores the mask bit as one.
- R11: While the mask bit is set, no interrupt pulse is produced. Each expiry yields exactly one pulse, and no pulse appears without an expiry.
- R12: Mode field 2'b11 is stored as written and behaves as one-shot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_en | input | 1 | Software enable; low forces the mask bit on configuration writes |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 config, 1 initial count, 2 deadline low, 3 deadline high/commit |
| wr_data | input | DATA_W | Write data |
| cfg_o | output | DATA_W | Stored configuration register |
| count_o | output | CNT_W | Current countdown value |
| deadline_o | output | TS_W | Committed deadline |
| timebase_o | output | TS_W | Free-running timebase |
| irq_o | output | 1 | Single-cycle interrupt request |

## Verification
The bench builds the block with a 16-bit count, a 32-bit data word and the 64-bit timebase. The short count width keeps several periodic reloads and both mode-rewrite sequences inside a few dozen cycles. Because the timebase starts at zero on reset, deadlines just ahead of or just behind the current time can be reached cheaply. Every expected interrupt cycle is predicted from the write cycle and compared against the exact cycle of each pulse.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    TM_ONESHOT  = 2'b00,
    TM_PERIODIC = 2'b01,
    TM_DEADLINE = 2'b10,
    TM_RSVD     = 2'b11
  } tmr_mode_e;

  typedef enum logic [1:0] {
    AD_CFG   = 2'd0,
    AD_INIT  = 2'd1,
    AD_DL_LO = 2'd2,
    AD_DL_HI = 2'd3
  } tmr_addr_e;

  localparam int VEC_LSB  = 0;
  localparam int VEC_W    = 8;
  localparam int MASK_BIT = 16;
  localparam int MODE_LSB = 17;
endpackage

// File: rtl/tmr_cfg_reg.sv
module tmr_cfg_reg
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_en,
  input  logic              wr_cfg,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] cfg_q,
  output logic              masked,
  output logic              periodic,
  output logic              dl_mode,
  output logic              disarm
);
  logic [DATA_W-1:0] cfg_next;
  tmr_mode_e         cur_mode;
  tmr_mode_e         new_mode;

  always_comb begin
    cfg_next = '0;
    cfg_next[VEC_LSB +: VEC_W] = wr_data[VEC_LSB +: VEC_W];
    cfg_next[MASK_BIT]         = wr_data[MASK_BIT] | ~sw_en;
    cfg_next[MODE_LSB +: 2]    = wr_data[MODE_LSB +: 2];
  end

  assign cur_mode = tmr_mode_e'(cfg_q[MODE_LSB +: 2]);
  assign new_mode = tmr_mode_e'(wr_data[MODE_LSB +: 2]);
  assign masked   = cfg_q[MASK_BIT];
  assign periodic = (cur_mode == TM_PERIODIC);
  assign dl_mode  = (cur_mode == TM_DEADLINE);
  // crossing the deadline boundary in either direction disarms
  assign disarm   = wr_cfg && ((new_mode == TM_DEADLINE) != dl_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q           <= '0;
      cfg_q[MASK_BIT] <= 1'b1;
    end else if (wr_cfg) begin
      cfg_q <= cfg_next;
    end
  end

  // R10: disabled software forces the mask bit
  a_r10_mask_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && !sw_en) |=> cfg_q[MASK_BIT]);
endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             periodic,
  input  logic             disarm,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] init_q;

  assign expire = (count == ONE) && !load && !disarm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      init_q <= '0;
    end else if (disarm) begin
      count <= '0;
    end else if (load) begin
      count  <= load_val;
      init_q <= load_val;
    end else if (count != '0) begin
      if (count == ONE && periodic) count <= init_q;
      else                          count <= count - ONE;
    end
  end

  // R1: a load places the written value in the count
  a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !disarm) |=> (count == $past(load_val)));
  // R7: disarm leaves the count at zero
  a_r7_disarm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    disarm |=> (count == '0));
  // R3: periodic expiry reloads
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && periodic) |=> (count == init_q));
  // R2: one step per clock without reload outside periodic mode
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    ((count != '0) && !periodic && !load && !disarm) |=> (count == $past(count) - ONE));
endmodule

// File: rtl/tmr_deadline.sv
module tmr_deadline #(
  parameter int DATA_W = 32,
  parameter int TS_W   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clear,
  input  logic              active,
  output logic [TS_W-1:0]   timebase,
  output logic [TS_W-1:0]   deadline,
  output logic              hit
);
  localparam int HI_W = TS_W - DATA_W;

  logic [DATA_W-1:0] stage_q;
  logic [TS_W-1:0]   commit_val;

  assign commit_val = {wdata[HI_W-1:0], stage_q};
  assign hit = active && (deadline != '0) && (timebase >= deadline) && !clear && !wr_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timebase <= '0;
      deadline <= '0;
      stage_q  <= '0;
    end else begin
      timebase <= timebase + TS_W'(1);
      if (wr_lo) stage_q <= wdata;
      if (clear)      deadline <= '0;
      else if (wr_hi) deadline <= commit_val;
      else if (hit)   deadline <= '0;
    end
  end

  // R9: a deadline match consumes the deadline
  a_r9_clear_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (deadline == '0));
  // R7: mode boundary crossing drops the deadline
  a_r7_deadline_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (deadline == '0));
endmodule

// File: rtl/mode_countdown_timer.sv
module mode_countdown_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int TS_W   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_en,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] cfg_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [TS_W-1:0]   deadline_o,
  output logic [TS_W-1:0]   timebase_o,
  output logic              irq_o
);
  logic wr_cfg, wr_init, wr_lo, wr_hi;
  logic masked, periodic, dl_mode, disarm;
  logic cnt_expire, dl_hit, load;

  assign wr_cfg  = wr_en && (wr_addr == AD_CFG);
  assign wr_init = wr_en && (wr_addr == AD_INIT);
  assign wr_lo   = wr_en && (wr_addr == AD_DL_LO);
  assign wr_hi   = wr_en && (wr_addr == AD_DL_HI);
  assign load    = wr_init && !dl_mode;

  tmr_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .wr_cfg(wr_cfg), .wr_data(wr_data),
    .cfg_q(cfg_o), .masked(masked), .periodic(periodic), .dl_mode(dl_mode),
    .disarm(disarm)
  );

  tmr_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(wr_data[CNT_W-1:0]),
    .periodic(periodic), .disarm(disarm), .count(count_o), .expire(cnt_expire)
  );

  tmr_deadline #(.DATA_W(DATA_W), .TS_W(TS_W)) u_dl (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(wr_data),
    .clear(disarm), .active(dl_mode), .timebase(timebase_o),
    .deadline(deadline_o), .hit(dl_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= (cnt_expire | dl_hit) & ~masked;
  end

  // R11: mask suppresses the next pulse
  a_r11_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    masked |=> !irq_o);
  // R8: initial-count writes in deadline mode do not touch the count
  a_r8_init_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_init && dl_mode) |=> $stable(count_o));
endmodule

// File: tb/sim_mode_countdown_timer.sv
`timescale 1ns/1ps
module sim_mode_countdown_timer;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int TS_W   = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sw_en = 1'b1;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] cfg_o;
  logic [CNT_W-1:0]  count_o;
  logic [TS_W-1:0]   deadline_o;
  logic [TS_W-1:0]   timebase_o;
  logic              irq_o;

  mode_countdown_timer #(.DATA_W(DATA_W), .CNT_W(CNT_W), .TS_W(TS_W)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_o(cfg_o), .count_o(count_o), .deadline_o(deadline_o),
    .timebase_o(timebase_o), .irq_o(irq_o)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  int irq_total = 0;
  int exp_q[$];
  bit done = 1'b0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: each pulse must match the next predicted cycle (R11)
  always @(negedge clk) begin
    if (rst_n && irq_o) begin
      irq_total++;
      if (exp_q.size() == 0) chk("R11 unexpected pulse", cyc, -1);
      else chk("R11 pulse cycle", cyc, exp_q.pop_front());
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8ns * 200000);
    chk("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    int w;
    longint t, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    chk("R10 reset cfg", cfg_o, 32'h0001_0000);
    chk("R1 reset count", count_o, 0);
    chk("R9 reset deadline", deadline_o, 0);
    chk("R11 reset irq", irq_o, 0);

    // R10 field isolation
    wr(2'd0, 32'h0000_0021);
    chk("R10 cfg write", cfg_o, 32'h21);
    wr(2'd0, 32'hFFF8_0021);
    chk("R10 undefined bits zero", cfg_o, 32'h21);

    // R1, R2 one-shot
    wr(2'd1, 32'd5); w = cyc; exp_q.push_back(w + 5);
    chk("R1 load", count_o, 5);
    idle(2); chk("R2 countdown", count_o, 3);
    idle(6); chk("R2 stays zero", count_o, 0);
    chk("R2 one pulse", irq_total, 1);

    // R3 periodic
    wr(2'd0, 32'h0002_0021);
    wr(2'd1, 32'd4); w = cyc;
    exp_q.push_back(w + 4); exp_q.push_back(w + 8); exp_q.push_back(w + 12);
    idle(13); chk("R3 reload", count_o, 3);
    wr(2'd1, 32'd0); chk("R1 zero stops", count_o, 0);
    idle(10); chk("R1 still stopped", count_o, 0);
    chk("R3 pulse count", irq_total, 4);

    // R4 one-shot -> periodic while running, R6 back to one-shot
    wr(2'd0, 32'h0000_0021);
    wr(2'd1, 32'd10); w = cyc;
    idle(3);
    wr(2'd0, 32'h0002_0021);
    chk("R4 count kept", count_o, 6);
    exp_q.push_back(w + 10);
    idle(11); chk("R4 wrapped", count_o, 5);
    wr(2'd0, 32'h0000_0021);
    exp_q.push_back(w + 20);
    idle(10); chk("R6 stops at zero", count_o, 0);
    chk("R6 pulse count", irq_total, 6);

    // R5 expired one-shot -> periodic
    wr(2'd0, 32'h0002_0021);
    idle(20); chk("R5 stays zero", count_o, 0);
    chk("R5 no pulse", irq_total, 6);

    // R11 mask
    wr(2'd0, 32'h0001_0021);
    wr(2'd1, 32'd3);
    idle(6); chk("R11 masked count expired", count_o, 0);
    chk("R11 masked no pulse", irq_total, 6);

    // R12 reserved mode acts as one-shot
    wr(2'd0, 32'h0006_0021);
    chk("R12 stored", cfg_o, 32'h0006_0021);
    wr(2'd1, 32'd3); w = cyc; exp_q.push_back(w + 3);
    idle(6); chk("R12 no reload", count_o, 0);
    chk("R12 one pulse", irq_total, 7);

    // R10 software disable
    sw_en = 1'b0;
    wr(2'd0, 32'h0000_0021);
    chk("R10 mask forced", cfg_o, 32'h0001_0021);
    sw_en = 1'b1;
    wr(2'd0, 32'h0000_0021);
    chk("R10 mask clear", cfg_o, 32'h21);

    // R7 into deadline mode, R8 ignored loads
    wr(2'd1, 32'd20);
    idle(2); chk("R7 running before", count_o, 18);
    wr(2'd0, 32'h0004_0021);
    chk("R7 entry clears count", count_o, 0);
    wr(2'd1, 32'd7);
    chk("R8 load ignored", count_o, 0);
    idle(25); chk("R7 no pulse", irq_total, 7);

    // R9 future deadline
    w = cyc; t = timebase_o; d = t + 20;
    exp_q.push_back(w + 21);
    wr(2'd2, d[31:0]); wr(2'd3, d[63:32]);
    chk("R9 committed", deadline_o, d);
    idle(25); chk("R9 cleared", deadline_o, 0);
    chk("R9 one pulse", irq_total, 8);

    // R9 past deadline
    t = timebase_o; d = t - 3;
    wr(2'd2, d[31:0]); wr(2'd3, d[63:32]);
    exp_q.push_back(cyc + 1);
    idle(3); chk("R9 past cleared", deadline_o, 0);
    chk("R9 past pulse", irq_total, 9);

    // R7 leaving deadline mode
    t = timebase_o; d = t + 1000;
    wr(2'd2, d[31:0]); wr(2'd3, d[63:32]);
    chk("R7 armed deadline", deadline_o, d);
    wr(2'd0, 32'h0002_0021);
    chk("R7 exit clears deadline", deadline_o, 0);
    chk("R7 exit count zero", count_o, 0);
    idle(5);
    chk("R11 all predicted pulses seen", exp_q.size(), 0);
    chk("R7 no pulse after exit", irq_total, 9);
    finish_run();
  end
endmodule